// File: doc/BRIEF.md
# Post-Configuration Wake-Up Sequencer

This block takes a programmable device from the "configuration loaded" condition into user mode in a controlled order. It controls four global events: output enable, release of write-disable, release of set/reset, and release of the open-drain DONE line. It releases them over four synchronous phases, T0 to T3. Each event is released in exactly one phase, and one phase may release several events. A select code chooses one of twenty release orders from a lookup that is computed, not stored.

Start is qualified by the internal configuration-complete flag. In automatic mode the sequence starts as soon as the flag is set, whatever level the external DONE line has. In external mode the sequence also waits until the DONE line, brought in through a two-flop synchroniser, is sensed high. After T3 the block rests in a terminal user-mode state with every event asserted. A phase status output lets the surrounding logic, or a bench, observe the progress.

Top module: `wake_sequencer`

## Requirements
- R1: While `rst_ni` is low, or while `int_done_i` is low, `phase_o` is 0 (idle) and `release_o` is 0. Phase codes are: 0 idle, 1 to 4 for T0 to T3, 5 user mode.
- R2: With `ext_mode_i` = 0, the first rising edge at which `int_done_i` is high moves the block from idle to T0, even when `done_pin_i` is low.
- R3: With `ext_mode_i` = 1, the block stays idle until `done_pin_i` has passed through two synchroniser flops. T0 is entered on the third rising edge after `done_pin_i` goes high, provided `int_done_i` is high.
- R4: Once started, the phase advances by one on each clock through T0, T1, T2 and T3. It then holds in user mode (5) with `release_o` equal to all ones.
- R5: For sequence s (0 to 19), let code = (13*s) mod 256. Event e is released in phase p_e = code bits [2e+1:2e], where 0 means T0 and 3 means T3. In phase Tk, bit e of `release_o` is 1 exactly when k >= p_e.
- R6: Bit order of `release_o`: bit 0 is global output enable, bit 1 is write-disable release, bit 2 is set/reset release, and bit 3 is DONE release.
- R7: A `seq_sel_i` value of 20 or more selects sequence 0.
- R8: The select code is captured on the idle-to-T0 transition. Changing `seq_sel_i` later in the sequence has no effect on `release_o`.
- R9: If `int_done_i` falls during any phase or in user mode, the next rising edge returns the block to idle with `release_o` equal to 0.
- R10: While `int_done_i` stays high, an event bit that has been set is never cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_done_i | input | 1 | Internal configuration-complete flag |
| done_pin_i | input | 1 | Sensed level of the external DONE line (asynchronous) |
| ext_mode_i | input | 1 | 1 = wait for the DONE line to be high before starting |
| seq_sel_i | input | 5 | Wake-up sequence select code |
| release_o | output | 4 | Event release vector (bit order per R6) |
| phase_o | output | 3 | Current phase code (per R1) |

## Verification
The bench sweeps every select code, including the out-of-range codes 20 to 31, in both start modes. At every phase it compares the release vector with the arithmetic table. A wrong table entry or a wrong comparison shows up as an event released one phase early or late. A broken fallback shows up as codes above 19 producing garbage orders. In external mode the bench counts the edges from the DONE line rising to T0. A missing or extra synchroniser stage moves that edge, and an ignored mode bit starts the sequence with the line low. The bench also changes the select code in mid-sequence to catch a design that does not capture it. It drops the done flag in mid-sequence to catch a design that keeps asserting events or fails to return to idle.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T0   = 3'd1,
        PH_T1   = 3'd2,
        PH_T2   = 3'd3,
        PH_T3   = 3'd4,
        PH_USER = 3'd5
    } phase_e;

    localparam int unsigned EVT_OE   = 0;
    localparam int unsigned EVT_WREN = 1;
    localparam int unsigned EVT_RST  = 2;
    localparam int unsigned EVT_DONE = 3;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q, chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

    // R3: a high output implies the pin was high STAGES edges before
    a_r3_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_o |-> $past(async_i, 2));
endmodule

// File: rtl/wake_seq_map.sv
module wake_seq_map #(
    parameter int unsigned NUM_EVT = 4,
    parameter int unsigned NUM_SEQ = 20,
    parameter int unsigned SEL_W   = 5,
    parameter int unsigned MULT    = 13
) (
    input  logic [SEL_W-1:0]           sel_i,
    output logic [NUM_EVT-1:0][1:0]    map_o
);
    localparam int unsigned CODE_W = 2 * NUM_EVT;

    logic [SEL_W-1:0]  eff_sel;
    logic [CODE_W-1:0] code;

    always_comb begin
        eff_sel = (32'(sel_i) >= NUM_SEQ) ? '0 : sel_i;
        code    = CODE_W'(CODE_W'(eff_sel) * CODE_W'(MULT));
    end

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        assign map_o[e] = code[2*e +: 2];
    end
endmodule

// File: rtl/wake_phase_fsm.sv
module wake_phase_fsm
    import wake_pkg::*;
#(
    parameter int unsigned NUM_EVT = 4,
    parameter int unsigned SEL_W   = 5
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     int_done_i,
    input  logic                     pin_sync_i,
    input  logic                     ext_mode_i,
    input  logic [SEL_W-1:0]         sel_i,
    input  logic [NUM_EVT-1:0][1:0]  map_i,
    output logic [SEL_W-1:0]         sel_nx_o,
    output logic [NUM_EVT-1:0]       release_o,
    output phase_e                   phase_o
);
    typedef struct packed {
        phase_e             phase;
        logic [SEL_W-1:0]   sel;
        logic [NUM_EVT-1:0] rel;
    } state_t;

    state_t st_d, st_q;
    logic   start_ok;
    logic [2:0] step_idx;

    always_comb begin
        st_d     = st_q;
        start_ok = int_done_i && (!ext_mode_i || pin_sync_i);
        if (!int_done_i) begin
            st_d.phase = PH_IDLE;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: if (start_ok) begin
                    st_d.phase = PH_T0;
                    st_d.sel   = sel_i;
                end
                PH_T0:   st_d.phase = PH_T1;
                PH_T1:   st_d.phase = PH_T2;
                PH_T2:   st_d.phase = PH_T3;
                PH_T3:   st_d.phase = PH_USER;
                PH_USER: st_d.phase = PH_USER;
                default: st_d.phase = PH_IDLE;
            endcase
        end
        step_idx = 3'(st_d.phase) - 3'd1;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (st_d.phase == PH_USER)
                st_d.rel[e] = 1'b1;
            else if (st_d.phase == PH_IDLE)
                st_d.rel[e] = 1'b0;
            else
                st_d.rel[e] = ({1'b0, map_i[e]} <= step_idx);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_IDLE;
            st_q.sel   <= '0;
            st_q.rel   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_nx_o  = st_d.sel;
    assign release_o = st_q.rel;
    assign phase_o   = st_q.phase;

    // R1: idle means nothing released
    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_IDLE) |-> (release_o == '0));

    // R4: one phase per clock while running
    a_r4_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_done_i && phase_o inside {PH_T0, PH_T1, PH_T2, PH_T3})
            |=> (3'(phase_o) == 3'($past(phase_o)) + 3'd1));

    // R4: user mode releases every event
    a_r4_user_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_USER) |-> (&release_o));

    // R9: losing the done flag returns to idle
    a_r9_drop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !int_done_i |=> (phase_o == PH_IDLE));

    // R10: released events stay released
    a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_done_i ##1 int_done_i |-> ((release_o & $past(release_o)) == $past(release_o)));
endmodule

// File: rtl/wake_sequencer.sv
module wake_sequencer
    import wake_pkg::*;
#(
    parameter int unsigned NUM_EVT     = 4,
    parameter int unsigned NUM_SEQ     = 20,
    parameter int unsigned SEL_W       = 5,
    parameter int unsigned MULT        = 13,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               int_done_i,
    input  logic               done_pin_i,
    input  logic               ext_mode_i,
    input  logic [SEL_W-1:0]   seq_sel_i,
    output logic [NUM_EVT-1:0] release_o,
    output logic [2:0]         phase_o
);
    logic                    pin_sync;
    logic [SEL_W-1:0]        sel_nx;
    logic [NUM_EVT-1:0][1:0] map;
    phase_e                  phase;

    wake_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (done_pin_i),
        .sync_o  (pin_sync)
    );

    wake_seq_map #(
        .NUM_EVT (NUM_EVT),
        .NUM_SEQ (NUM_SEQ),
        .SEL_W   (SEL_W),
        .MULT    (MULT)
    ) map_i (
        .sel_i (sel_nx),
        .map_o (map)
    );

    wake_phase_fsm #(
        .NUM_EVT (NUM_EVT),
        .SEL_W   (SEL_W)
    ) fsm_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .int_done_i (int_done_i),
        .pin_sync_i (pin_sync),
        .ext_mode_i (ext_mode_i),
        .sel_i      (seq_sel_i),
        .map_i      (map),
        .sel_nx_o   (sel_nx),
        .release_o  (release_o),
        .phase_o    (phase)
    );

    assign phase_o = 3'(phase);
endmodule

// File: tb/wake_sequencer_tb.sv
`timescale 1ns/1ps
module wake_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       int_done = 1'b0;
    logic       pin = 1'b0;
    logic       ext_mode = 1'b0;
    logic [4:0] sel = '0;
    logic [3:0] rel;
    logic [2:0] phase;

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    wake_sequencer dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .int_done_i (int_done),
        .done_pin_i (pin),
        .ext_mode_i (ext_mode),
        .seq_sel_i  (sel),
        .release_o  (rel),
        .phase_o    (phase)
    );

    // R5/R7 expected release vector for phase code ph and select s
    function automatic logic [3:0] exp_rel(input int s, input int ph);
        int eff, code, p;
        logic [3:0] r;
        eff  = (s >= 20) ? 0 : s;
        code = (eff * 13) % 256;
        r = '0;
        for (int e = 0; e < 4; e++) begin
            p = (code >> (2 * e)) & 3;
            if (ph == 5) r[e] = 1'b1;
            else if (ph >= 1 && ph <= 4) r[e] = ((ph - 1) >= p);
        end
        return r;
    endfunction

    task automatic check(input string req, input int exp_ph, input logic [3:0] exp_r);
        checks++;
        if (phase !== 3'(exp_ph) || rel !== exp_r) begin
            failures++;
            $display("FAIL %s: phase=%0d release=%b expected phase=%0d release=%b",
                     req, phase, rel, exp_ph, exp_r);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done_flag) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step();
        check("R1 reset", 0, 4'b0000);
        int_done = 1'b1;
        step();
        check("R1 in reset with done high", 0, 4'b0000);
        int_done = 1'b0;
        rst_n = 1'b1;
        step();
        check("R1 done low", 0, 4'b0000);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 32; s++) begin
                int_done = 1'b0;
                pin = 1'b0;
                ext_mode = m[0];
                sel = 5'(s);
                for (int k = 0; k < 3; k++) step();
                check("R1 idle between runs", 0, 4'b0000);
                int_done = 1'b1;
                if (m == 1) begin
                    for (int k = 0; k < 3; k++) begin
                        step();
                        check("R3 hold with pin low", 0, 4'b0000);
                    end
                    pin = 1'b1;
                    step();
                    check("R3 sync stage 1", 0, 4'b0000);
                    step();
                    check("R3 sync stage 2", 0, 4'b0000);
                end
                step();
                check(m == 1 ? "R3 start T0" : "R2 auto start T0", 1, exp_rel(s, 1));
                sel = 5'((s + 7) % 32);
                for (int ph = 2; ph <= 4; ph++) begin
                    step();
                    check(s >= 20 ? "R7 fallback phase" : "R5 R6 R8 phase", ph, exp_rel(s, ph));
                end
                step();
                check("R4 user mode", 5, 4'b1111);
                step();
                check("R4 user hold", 5, 4'b1111);
            end
        end

        // R9: drop the done flag in mid-sequence
        int_done = 1'b0; pin = 1'b0; ext_mode = 1'b0; sel = 5'd5;
        for (int k = 0; k < 3; k++) step();
        int_done = 1'b1;
        step();
        check("R9 start", 1, exp_rel(5, 1));
        step();
        check("R9 T1", 2, exp_rel(5, 2));
        int_done = 1'b0;
        step();
        check("R9 drop to idle", 0, 4'b0000);
        step();
        check("R9 stays idle", 0, 4'b0000);

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule